// File: doc/BRIEF.md
# Beam-Pruned Viterbi Frame Updater

This block advances a hidden Markov model by one time frame. Every state score is a log-domain value, so multiplying probabilities becomes adding scores. On a start pulse the block goes through every state in ascending index order. For each state it reads that state's predecessor slots from an external topology memory. Each slot that is valid and points at a live predecessor yields a candidate: the predecessor's score from the previous frame, plus the slot's transition score, plus the state's observation log-probability. The block keeps the largest candidate.

The new score is then compared with a beam. A state survives only if its score lies within `BEAM` of the best surviving score of the previous frame. A state that fails is marked dead, reads as the most negative score, and is never used as a predecessor in the next frame.

Scores sit in two internal banks that trade roles at each frame boundary: one is read while the other is written. For every state the block emits one result: the new score, plus a backpointer to the winning predecessor that an external backtracking stage can store. A done pulse marks the last result of the frame.

Top module: `vit_frame_update`

## Requirements
- R1: Each accepted start produces exactly `N_STATES` results, in ascending state order starting at 0. Each result is issued only while the frame is busy, except the last one, which comes together with done. Predecessor scores used in a frame are the results of the previous frame.
- R2: A state's new score is the maximum of the saturated sum (predecessor score + transition score + observation score of this state). The maximum is taken over all valid slots whose predecessor is live.
- R3: `res_bp` is the predecessor index of the winning slot. When candidates tie, the lowest slot index wins. A state with no candidate reports score -32768 and backpointer 0.
- R4: A state survives only if its score is not -32768 and is at least the saturated value (previous-frame best − `BEAM`). A state that fails is reported and stored as -32768 and contributes no candidate in the next frame.
- R5: The beam reference is the highest surviving score of the previous frame. After reset it is 0. It is not the best score of the frame being computed.
- R6: Topology word at address {state, slot}: bit `IDX_W+SCORE_W` is valid, bits `[SCORE_W +: IDX_W]` are the predecessor index, bits `[SCORE_W-1:0]` are the signed transition score. Slots with valid=0 are ignored whatever their other fields hold, so the number of predecessors can differ from state to state.
- R7: Sums saturate to the range 32767 / -32768, and a sum saturated to -32768 counts as no candidate.
- R8: After reset, state `INIT_STATE` holds score 0 and every other state is dead. `frame_busy`, `frame_done` and `res_valid` are low.
- R9: `frame_busy` rises only in the cycle after a start seen while idle. `frame_done` is a one-cycle pulse that comes with the last result, with busy low. A start seen while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame when idle |
| topo_addr | output | IDX_W+SLOT_W | Topology read address {state, slot} |
| topo_rdata | input | 1+IDX_W+SCORE_W | Topology word, one cycle after the address |
| obs_addr | output | IDX_W | Observation score read address (state) |
| obs_rdata | input | SCORE_W | Signed observation log-probability, one cycle after the address |
| frame_busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse with the last result of a frame |
| res_valid | output | 1 | Result strobe |
| res_state | output | IDX_W | State index of the result |
| res_score | output | SCORE_W | New signed score, -32768 if dead |
| res_bp | output | IDX_W | Winning predecessor index |

## Verification
A chain topology, where each state has a self loop and a forward edge, runs over several frames. It shows whether the banks trade roles correctly and whether scores carry from frame to frame. A fan-out frame sets one state just outside the beam, one just inside the beam relative to the previous best but outside relative to the current best, and one high state. This separates the previous-best rule from a running-best rule and confirms that a pruned state feeds nothing afterwards. Further frames with paired equal candidates in both slot orders, invalid slots carrying large transitions, and sums beyond both score limits check tie-breaking, slot masking and saturation. A start pulsed during a busy frame checks that the frame is neither restarted nor lengthened.

// File: rtl/vit_pkg.sv
package vit_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FETCH,
    PH_EVAL,
    PH_WRITE
  } vit_phase_e;
endpackage

// File: rtl/vit_sat_add.sv
// Three-operand signed adder clamped to the score range.
module vit_sat_add #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic signed [W-1:0] c,
  output logic signed [W-1:0] y
);
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] HI = EW'((2 ** (W - 1)) - 1);
  localparam logic signed [EW-1:0] LO = -HI - 1;

  logic signed [EW-1:0] sum;

  always_comb begin
    sum = EW'(a) + EW'(b) + EW'(c);
    if (sum > HI)      y = W'(HI);
    else if (sum < LO) y = W'(LO);
    else               y = sum[W-1:0];
  end
endmodule

// File: rtl/vit_score_banks.sv
// Two score banks with live flags. One is read as the previous frame, the other written.
module vit_score_banks #(
  parameter int N_STATES   = 8,
  parameter int W          = 16,
  parameter int INIT_STATE = 0,
  localparam int IDX_W     = $clog2(N_STATES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_bank,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic signed [W-1:0] rd_score,
  input  logic                wr_en,
  input  logic                wr_bank,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic signed [W-1:0] wr_score,
  input  logic                wr_alive,
  input  logic                boot_done
);
  localparam logic signed [W-1:0] MIN_SCORE = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] bank_rd [2];
  logic                boot_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic signed [W-1:0] mem [N_STATES];
    logic [N_STATES-1:0] alv;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_idx] <= wr_score;
    end

    always_ff @(posedge clk) begin
      if (rst) alv <= '0;
      else if (wr_en && (wr_bank == 1'(b))) alv[wr_idx] <= wr_alive;
    end

    assign bank_rd[b] = alv[rd_idx] ? mem[rd_idx] : MIN_SCORE;
  end

  // Until the first frame ends, the read bank reflects the seed state only.
  always_ff @(posedge clk) begin
    if (rst) boot_q <= 1'b1;
    else if (boot_done) boot_q <= 1'b0;
  end

  always_comb begin
    if (boot_q) rd_score = (rd_idx == IDX_W'(INIT_STATE)) ? '0 : MIN_SCORE;
    else        rd_score = bank_rd[rd_bank];
  end
endmodule

// File: rtl/vit_frame_update.sv
module vit_frame_update #(
  parameter int N_STATES   = 8,
  parameter int MAX_PRED   = 4,
  parameter int SCORE_W    = 16,
  parameter int BEAM       = 1000,
  parameter int INIT_STATE = 0,
  localparam int IDX_W     = $clog2(N_STATES),
  localparam int SLOT_W    = $clog2(MAX_PRED),
  localparam int TOPO_AW   = IDX_W + SLOT_W,
  localparam int TOPO_DW   = 1 + IDX_W + SCORE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  output logic [TOPO_AW-1:0]        topo_addr,
  input  logic [TOPO_DW-1:0]        topo_rdata,
  output logic [IDX_W-1:0]          obs_addr,
  input  logic signed [SCORE_W-1:0] obs_rdata,
  output logic                      frame_busy,
  output logic                      frame_done,
  output logic                      res_valid,
  output logic [IDX_W-1:0]          res_state,
  output logic signed [SCORE_W-1:0] res_score,
  output logic [IDX_W-1:0]          res_bp
);
  import vit_pkg::*;

  localparam logic signed [SCORE_W-1:0] MIN_SCORE = {1'b1, {(SCORE_W-1){1'b0}}};
  localparam logic signed [SCORE_W-1:0] NEG_BEAM  = SCORE_W'(-BEAM);
  localparam logic [IDX_W-1:0]          LAST_ST   = IDX_W'(N_STATES - 1);
  localparam logic [SLOT_W-1:0]         LAST_SLOT = SLOT_W'(MAX_PRED - 1);

  vit_phase_e                phase_q;
  logic [IDX_W-1:0]          st_q;
  logic [SLOT_W-1:0]         slot_q;
  logic                      cur_q;
  logic signed [SCORE_W-1:0] best_q, frame_best_q, prev_best_q;
  logic [IDX_W-1:0]          bp_q;

  // Topology word fields
  logic                      t_valid;
  logic [IDX_W-1:0]          t_pred;
  logic signed [SCORE_W-1:0] t_trans;
  assign t_valid = topo_rdata[TOPO_DW-1];
  assign t_pred  = topo_rdata[SCORE_W +: IDX_W];
  assign t_trans = topo_rdata[SCORE_W-1:0];

  logic signed [SCORE_W-1:0] pred_score, cand, thr, fb_next, store_score;
  logic                      cand_win, keep, wr_en, last_write;

  vit_score_banks #(
    .N_STATES(N_STATES), .W(SCORE_W), .INIT_STATE(INIT_STATE)
  ) banks_i (
    .clk(clk), .rst(rst),
    .rd_bank(cur_q), .rd_idx(t_pred), .rd_score(pred_score),
    .wr_en(wr_en), .wr_bank(~cur_q), .wr_idx(st_q),
    .wr_score(store_score), .wr_alive(keep),
    .boot_done(last_write)
  );

  vit_sat_add #(.W(SCORE_W)) cand_add_i (
    .a(pred_score), .b(t_trans), .c(obs_rdata), .y(cand)
  );

  vit_sat_add #(.W(SCORE_W)) beam_add_i (
    .a(prev_best_q), .b(NEG_BEAM), .c('0), .y(thr)
  );

  always_comb begin
    cand_win    = t_valid && (pred_score != MIN_SCORE) && (cand > best_q);
    keep        = (best_q != MIN_SCORE) && (best_q >= thr);
    store_score = keep ? best_q : MIN_SCORE;
    fb_next     = (keep && (best_q > frame_best_q)) ? best_q : frame_best_q;
    wr_en       = (phase_q == PH_WRITE);
    last_write  = wr_en && (st_q == LAST_ST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_IDLE;
      st_q         <= '0;
      slot_q       <= '0;
      cur_q        <= 1'b0;
      best_q       <= MIN_SCORE;
      bp_q         <= '0;
      frame_best_q <= MIN_SCORE;
      prev_best_q  <= '0;
      topo_addr    <= '0;
      obs_addr     <= '0;
      frame_busy   <= 1'b0;
      frame_done   <= 1'b0;
      res_valid    <= 1'b0;
      res_state    <= '0;
      res_score    <= '0;
      res_bp       <= '0;
    end else begin
      frame_done <= 1'b0;
      res_valid  <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            frame_busy   <= 1'b1;
            st_q         <= '0;
            slot_q       <= '0;
            best_q       <= MIN_SCORE;
            bp_q         <= '0;
            frame_best_q <= MIN_SCORE;
            topo_addr    <= '0;
            obs_addr     <= '0;
            phase_q      <= PH_FETCH;
          end
        end
        PH_FETCH: phase_q <= PH_EVAL;
        PH_EVAL: begin
          if (cand_win) begin
            best_q <= cand;
            bp_q   <= t_pred;
          end
          if (slot_q == LAST_SLOT) begin
            phase_q <= PH_WRITE;
          end else begin
            slot_q    <= slot_q + 1'b1;
            topo_addr <= {st_q, slot_q + 1'b1};
            phase_q   <= PH_FETCH;
          end
        end
        PH_WRITE: begin
          res_valid    <= 1'b1;
          res_state    <= st_q;
          res_score    <= store_score;
          res_bp       <= bp_q;
          frame_best_q <= fb_next;
          if (st_q == LAST_ST) begin
            frame_done  <= 1'b1;
            frame_busy  <= 1'b0;
            cur_q       <= ~cur_q;
            prev_best_q <= fb_next;
            phase_q     <= PH_IDLE;
          end else begin
            st_q      <= st_q + 1'b1;
            slot_q    <= '0;
            best_q    <= MIN_SCORE;
            bp_q      <= '0;
            topo_addr <= {st_q + 1'b1, SLOT_W'(0)};
            obs_addr  <= st_q + 1'b1;
            phase_q   <= PH_FETCH;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vit_frame_update_chk.sv
module vit_frame_update_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             frame_busy,
  input logic             frame_done,
  input logic             res_valid,
  input logic [IDX_W-1:0] res_state
);
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else if (res_valid) last_q <= res_state;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!frame_busy && res_valid));

  // R9
  busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_busy) |-> $past(start));

  // R1
  result_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !frame_done) |-> frame_busy);

  // R1
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (res_state != '0)) |-> (last_q == IDX_W'(res_state - 1'b1)));
endmodule

bind vit_frame_update vit_frame_update_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .frame_busy(frame_busy),
  .frame_done(frame_done), .res_valid(res_valid), .res_state(res_state)
);

// File: tb/vit_frame_update_tb_top.sv
module vit_frame_update_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 8;
  localparam int MP     = 4;
  localparam int W      = 16;
  localparam int BEAM   = 1000;
  localparam int IDX_W  = $clog2(N);
  localparam int SLOT_W = $clog2(MP);
  localparam int TAW    = IDX_W + SLOT_W;
  localparam int TDW    = 1 + IDX_W + W;
  localparam int MINV   = -32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [TAW-1:0] topo_addr;
  logic [TDW-1:0] topo_rdata;
  logic [IDX_W-1:0] obs_addr;
  logic signed [W-1:0] obs_rdata;
  logic frame_busy, frame_done, res_valid;
  logic [IDX_W-1:0] res_state, res_bp;
  logic signed [W-1:0] res_score;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vit_frame_update #(.N_STATES(N), .MAX_PRED(MP), .SCORE_W(W), .BEAM(BEAM), .INIT_STATE(0)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .topo_addr(topo_addr), .topo_rdata(topo_rdata),
    .obs_addr(obs_addr), .obs_rdata(obs_rdata),
    .frame_busy(frame_busy), .frame_done(frame_done),
    .res_valid(res_valid), .res_state(res_state),
    .res_score(res_score), .res_bp(res_bp)
  );

  // External memories with one cycle read latency
  logic [TDW-1:0] topo_mem [N*MP];
  logic signed [W-1:0] obs_mem [N];
  always_ff @(posedge clk) begin
    topo_rdata <= topo_mem[topo_addr];
    obs_rdata  <= obs_mem[obs_addr];
  end

  int checks = 0;
  int failures = 0;
  int m_score [N];
  bit m_alive [N];
  int m_prev;
  int e_score [N];
  int e_bp [N];
  int e_best;

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start = 1'b0;
    for (int i = 0; i < N * MP; i++) topo_mem[i] = '0;
    for (int i = 0; i < N; i++) begin
      obs_mem[i] = '0;
      m_score[i] = MINV;
      m_alive[i] = 1'b0;
    end
    m_score[0] = 0;
    m_alive[0] = 1'b1;
    m_prev = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_edge(int s, int k, bit v, int pred, int trans);
    topo_mem[s * MP + k] = {v, IDX_W'(pred), W'(trans)};
  endtask

  // Expected frame from R2..R7
  task automatic predict();
    int thr;
    thr = sat(m_prev - BEAM);
    e_best = MINV;
    for (int s = 0; s < N; s++) begin
      int best;
      int bp;
      best = MINV;
      bp = 0;
      for (int k = 0; k < MP; k++) begin
        logic [TDW-1:0] w;
        logic signed [W-1:0] tr;
        int p;
        int c;
        w  = topo_mem[s * MP + k];
        tr = w[W-1:0];
        p  = int'(w[W +: IDX_W]);
        if (w[TDW-1] && m_alive[p]) begin
          c = sat(m_score[p] + int'(tr) + int'(obs_mem[s]));
          if (c > best) begin
            best = c;
            bp = p;
          end
        end
      end
      if (best != MINV && best >= thr) begin
        e_score[s] = best;
        if (best > e_best) e_best = best;
      end else begin
        e_score[s] = MINV;
      end
      e_bp[s] = bp;
    end
  endtask

  task automatic run_frame(string req, bit poke);
    int s;
    int guard;
    predict();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s = 0;
    guard = 0;
    while (s < N && guard < 2000) begin
      if (res_valid) begin
        check(res_state == IDX_W'(s), "R1", "result order", int'(res_state), s);
        check(int'(res_score) == e_score[s], req, $sformatf("score of state %0d", s), int'(res_score), e_score[s]);
        check(int'(res_bp) == e_bp[s], "R3", $sformatf("backpointer of state %0d", s), int'(res_bp), e_bp[s]);
        check(frame_done == (s == N - 1), "R9", "done with last result", int'(frame_done), int'(s == N - 1));
        check(frame_busy == (s != N - 1), "R9", "busy during frame", int'(frame_busy), int'(s != N - 1));
        s++;
      end
      start = poke && (s == 3);
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check(s == N, "R1", "results per frame", s, N);
    for (int i = 0; i < N; i++) begin
      m_score[i] = e_score[i];
      m_alive[i] = (e_score[i] != MINV);
    end
    m_prev = e_best;
  endtask

  task automatic test_reset();
    do_reset();
    check(frame_busy == 1'b0, "R8", "busy after reset", int'(frame_busy), 0);
    check(frame_done == 1'b0, "R8", "done after reset", int'(frame_done), 0);
    check(res_valid == 1'b0, "R8", "valid after reset", int'(res_valid), 0);
  endtask

  // R1 R2: chain with self loops across several frames
  task automatic test_chain();
    do_reset();
    for (int s = 0; s < N; s++) begin
      set_edge(s, 0, 1'b1, s, -2);
      if (s > 0) set_edge(s, 1, 1'b1, s - 1, -7);
      obs_mem[s] = W'(-3 * (s + 1));
    end
    for (int f = 0; f < 4; f++) run_frame("R2", 1'b0);
  endtask

  // R4 R5: beam against previous best, pruned state feeds nothing
  task automatic test_beam();
    do_reset();
    set_edge(0, 0, 1'b1, 0, 0);
    set_edge(1, 0, 1'b1, 0, -1500);
    set_edge(2, 0, 1'b1, 0, -900);
    set_edge(3, 0, 1'b1, 0, 2000);
    set_edge(4, 0, 1'b1, 0, -999);
    run_frame("R4 R5", 1'b0);
    check(m_alive[4] && !m_alive[1], "R5", "reference is previous best", int'(m_alive[4]), 1);
    for (int i = 0; i < N * MP; i++) topo_mem[i] = '0;
    set_edge(0, 0, 1'b1, 0, 0);
    set_edge(3, 0, 1'b1, 3, 0);
    set_edge(5, 0, 1'b1, 1, 5000);
    set_edge(6, 0, 1'b1, 4, 0);
    run_frame("R4", 1'b0);
    check(!m_alive[5], "R4", "pruned predecessor not expanded", int'(m_alive[5]), 0);
  endtask

  // R3 R6: ties in both slot orders and invalid slots
  task automatic test_ties();
    do_reset();
    set_edge(0, 0, 1'b1, 0, 0);
    set_edge(1, 0, 1'b1, 0, -10);
    run_frame("R2", 1'b0);
    for (int i = 0; i < N * MP; i++) topo_mem[i] = '0;
    set_edge(2, 0, 1'b1, 1, 0);
    set_edge(2, 1, 1'b1, 0, -10);
    set_edge(3, 0, 1'b1, 0, -10);
    set_edge(3, 1, 1'b1, 1, 0);
    set_edge(4, 0, 1'b0, 0, 500);
    set_edge(4, 3, 1'b1, 1, 7);
    run_frame("R6", 1'b0);
    check(e_bp[2] == 1 && e_bp[3] == 0, "R3", "tie goes to lowest slot", e_bp[2], 1);
  endtask

  // R7: clamping at both ends
  task automatic test_saturation();
    do_reset();
    set_edge(0, 0, 1'b1, 0, 30000);
    obs_mem[0] = W'(30000);
    set_edge(1, 0, 1'b1, 0, -32000);
    obs_mem[1] = W'(-32000);
    set_edge(2, 0, 1'b1, 0, 0);
    run_frame("R7", 1'b0);
    check(m_score[0] == 32767, "R7", "positive clamp", m_score[0], 32767);
    run_frame("R7", 1'b0);
  endtask

  // R9: start while busy ignored
  task automatic test_busy_start();
    do_reset();
    set_edge(0, 0, 1'b1, 0, -1);
    set_edge(1, 0, 1'b1, 0, -4);
    run_frame("R9", 1'b1);
    for (int i = 0; i < 6; i++) begin
      check(frame_busy == 1'b0 && res_valid == 1'b0, "R9", "no restart after busy start",
            int'(frame_busy), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_chain();
    test_beam();
    test_ties();
    test_saturation();
    test_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule